// File: doc/BRIEF.md
# Sleep-Mode Wake-Up Detector

This block watches for wake-up requests while the bus transceiver is in its low-power sleep state. It has two independent channels. The remote channel looks at three digitised bus-level flags from analog comparators outside the block: below the pre-wake low threshold, dominant, and above the pre-wake high threshold. The local channel looks at the digitised level of an active-low wake switch. All four flags pass through a two-stage synchroniser before any state machine sees them. All durations are parameters counted in clock cycles.

A remote wake needs a complete sequence. The bus must first fall below the pre-wake low threshold. This turns the bus receiver on and opens a monitoring window. Inside the window the bus must then stay dominant for longer than the bus filter time. Release from dominant then produces a one-cycle remote-wake pulse. If the window closes while the bus is floating, the receiver is turned off again and the channel locks out. If the window closes while the bus is still dominant, as with a short to ground, the receiver is turned off and the next release from dominant produces the wake directly. A local wake needs the switch input held low for longer than the local filter time. After a wake, and after a failed attempt, each channel stays locked until its input has been recessive or high for a minimum time.

Detection runs only while the sleep input is high. Dropping sleep sends both channels to idle on the next clock edge and discards any partial qualification. The mode controller reads the two wake pulses and the receiver-enable output. When both channels qualify in the same cycle, both pulses are issued together, and the controller gives the local source priority.

Top module: `sleep_wake_detect`

Remote channel states: R_IDLE (not sleeping), R_LOCK (waiting for a recessive interval), R_ARMED (waiting for pre-wake low), R_MON (monitoring window, receiver on), R_QUAL (dominant qualified, waiting for release), R_SHORT (window ended while dominant, receiver off), R_FIRE (pulse cycle).

Remote transitions:
- IDLE to LOCK on sleep.
- LOCK to ARMED after the recessive interval.
- ARMED to MON on pre-wake low.
- MON to QUAL on a filtered dominant level.
- MON to SHORT when the window ends while dominant.
- MON to LOCK when the window ends while not dominant.
- QUAL to FIRE on release.
- QUAL to SHORT when the window ends.
- SHORT to FIRE on release.
- FIRE to LOCK.
- Any state to IDLE when sleep is low.

Local channel states: L_IDLE, L_LOCK (waiting for a high interval), L_ARMED, L_FILT (counting the low level), L_FIRE.

Local transitions:
- IDLE to LOCK on sleep.
- LOCK to ARMED after the high interval.
- ARMED to FILT on low.
- FILT back to ARMED on high.
- FILT to FIRE when the filter time is reached.
- FIRE to LOCK.
- Any state to IDLE when sleep is low.

## Requirements
- R1: While sleep_i is low, all three outputs are low on the next cycle, whatever the inputs do. Deasserting sleep_i for even one cycle drops rx_enable_o on the following cycle and discards any partial qualification on either channel.
- R2: On entry into sleep, each channel starts locked. The local channel needs wake_sw_n_i high on LOC_REARM_CYC+1 consecutive synchronised cycles before a low level can start filtering. The remote channel needs the same with bus_above_prewake_i and BUS_REARM_CYC.
- R3: From the armed state, bus_below_prewake_i going high at a clock edge makes rx_enable_o high exactly three cycles later: two synchroniser stages plus the state register.
- R4: A remote wake needs bus_dominant_i high on at least BUS_FILT_CYC+1 consecutive synchronised cycles inside the window. The first cycle may be the one that opens the window. The dominant release then raises remote_wake_o three cycles after the release edge. Exactly BUS_FILT_CYC dominant cycles give no wake.
- R5: rx_enable_o stays high for exactly MON_CYC cycles and then falls. If the bus was not dominant at that point, no remote wake follows.
- R6: If the window ends while the bus is dominant, rx_enable_o falls. A later dominant release then raises remote_wake_o three cycles after the release edge, while rx_enable_o stays low.
- R7: After a remote wake or a failed attempt, no remote wake can occur until bus_above_prewake_i has been high on BUS_REARM_CYC+1 consecutive synchronised cycles. The receiver also stays off during this lockout.
- R8: wake_sw_n_i low on LOC_FILT_CYC+1 consecutive synchronised cycles gives a local_wake_o pulse LOC_FILT_CYC+3 cycles after the falling edge. A low of LOC_FILT_CYC cycles gives none.
- R9: After a local wake, a continued low produces no further pulse. A high of LOC_REARM_CYC cycles does not re-arm; a high of LOC_REARM_CYC+1 cycles does.
- R10: Each wake pulse lasts exactly one cycle. When both channels qualify on the same edge, remote_wake_o and local_wake_o are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High while the transceiver is in sleep mode |
| bus_below_prewake_i | input | 1 | Bus is below the pre-wake low threshold (asynchronous) |
| bus_dominant_i | input | 1 | Bus is at the dominant level (asynchronous) |
| bus_above_prewake_i | input | 1 | Bus is above the pre-wake high threshold (asynchronous) |
| wake_sw_n_i | input | 1 | Wake switch level, low means pressed (asynchronous) |
| rx_enable_o | output | 1 | Bus receiver enable during the monitoring window |
| remote_wake_o | output | 1 | One-cycle remote wake pulse |
| local_wake_o | output | 1 | One-cycle local wake pulse |

## Verification
A wrong state shows up quickly at the ports. A remote channel stuck in or skipping its window changes rx_enable_o exactly three cycles after the pre-wake edge, or exactly MON_CYC cycles later. A wrong lockout or filter count moves a wake pulse by a whole cycle, adds one, or removes one. The directed tests sample at those exact cycles. Counters that fail to clear on a sleep exit appear as a wake that should have been discarded. A channel left outside its lock after a wake appears as a second pulse while the input is still low.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [2:0] {
        R_IDLE,
        R_LOCK,
        R_ARMED,
        R_MON,
        R_QUAL,
        R_SHORT,
        R_FIRE
    } rem_state_t;

    typedef enum logic [2:0] {
        L_IDLE,
        L_LOCK,
        L_ARMED,
        L_FILT,
        L_FIRE
    } loc_state_t;

endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/swd_remote.sv
module swd_remote
    import swd_pkg::*;
#(
    parameter int FILT_CYC  = 90,
    parameter int MON_CYC   = 10000,
    parameter int REARM_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic lo_i,
    input  logic dom_i,
    input  logic hi_i,
    output logic rx_en_o,
    output logic wake_o
);

    localparam int PH_MAX = (FILT_CYC > REARM_CYC) ? FILT_CYC : REARM_CYC;
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam int MW     = $clog2(MON_CYC + 1);
    localparam logic [PW-1:0] FILT_V  = PW'(FILT_CYC);
    localparam logic [PW-1:0] REARM_V = PW'(REARM_CYC);
    localparam logic [MW-1:0] MON_END = MW'(MON_CYC - 1);

    rem_state_t    state, state_n;
    logic [PW-1:0] ph, ph_n;
    logic [MW-1:0] mon, mon_n;

    // next-state and counter logic
    always_comb begin
        state_n = state;
        ph_n    = ph;
        mon_n   = mon;
        if (!sleep_i) begin
            state_n = R_IDLE;
            ph_n    = '0;
            mon_n   = '0;
        end else begin
            unique case (state)
                R_IDLE: begin
                    state_n = R_LOCK;
                    ph_n    = '0;
                end
                R_LOCK: begin
                    if (hi_i) begin
                        if (ph == REARM_V) begin
                            state_n = R_ARMED;
                            ph_n    = '0;
                        end else begin
                            ph_n = ph + 1'b1;
                        end
                    end else begin
                        ph_n = '0;
                    end
                end
                R_ARMED: begin
                    if (lo_i) begin
                        state_n = R_MON;
                        mon_n   = '0;
                        ph_n    = PW'(dom_i);
                    end
                end
                R_MON: begin
                    if (mon == MON_END) begin
                        state_n = dom_i ? R_SHORT : R_LOCK;
                        ph_n    = '0;
                    end else begin
                        mon_n = mon + 1'b1;
                        if (dom_i) begin
                            if (ph == FILT_V) state_n = R_QUAL;
                            else              ph_n    = ph + 1'b1;
                        end else begin
                            ph_n = '0;
                        end
                    end
                end
                R_QUAL: begin
                    if (!dom_i) begin
                        state_n = R_FIRE;
                    end else if (mon == MON_END) begin
                        state_n = R_SHORT;
                    end else begin
                        mon_n = mon + 1'b1;
                    end
                end
                R_SHORT: begin
                    if (!dom_i) state_n = R_FIRE;
                end
                R_FIRE: begin
                    state_n = R_LOCK;
                    ph_n    = '0;
                end
                default: state_n = R_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= R_IDLE;
            ph    <= '0;
            mon   <= '0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            mon   <= mon_n;
        end
    end

    // outputs
    always_comb begin
        rx_en_o = 1'b0;
        wake_o  = 1'b0;
        unique case (state)
            R_MON, R_QUAL: rx_en_o = 1'b1;
            R_FIRE:        wake_o  = 1'b1;
            default: begin
                rx_en_o = 1'b0;
                wake_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/swd_local.sv
module swd_local
    import swd_pkg::*;
#(
    parameter int FILT_CYC  = 35,
    parameter int REARM_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic sw_n_i,
    output logic wake_o
);

    localparam int CMAX = (FILT_CYC > REARM_CYC) ? FILT_CYC : REARM_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] FILT_V  = CW'(FILT_CYC);
    localparam logic [CW-1:0] REARM_V = CW'(REARM_CYC);
    localparam logic [CW-1:0] ONE_V   = CW'(1);

    loc_state_t    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!sleep_i) begin
            state_n = L_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state)
                L_IDLE: begin
                    state_n = L_LOCK;
                    cnt_n   = '0;
                end
                L_LOCK: begin
                    if (sw_n_i) begin
                        if (cnt == REARM_V) begin
                            state_n = L_ARMED;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end else begin
                        cnt_n = '0;
                    end
                end
                L_ARMED: begin
                    if (!sw_n_i) begin
                        state_n = L_FILT;
                        cnt_n   = ONE_V;
                    end
                end
                L_FILT: begin
                    if (sw_n_i) begin
                        state_n = L_ARMED;
                        cnt_n   = '0;
                    end else if (cnt == FILT_V) begin
                        state_n = L_FIRE;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                L_FIRE: begin
                    state_n = L_LOCK;
                    cnt_n   = '0;
                end
                default: state_n = L_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= L_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        unique case (state)
            L_FIRE:  wake_o = 1'b1;
            default: wake_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sleep_wake_detect.sv
module sleep_wake_detect #(
    parameter int SYNC_STAGES   = 2,
    parameter int BUS_FILT_CYC  = 90,
    parameter int MON_CYC       = 10000,
    parameter int BUS_REARM_CYC = 4,
    parameter int LOC_FILT_CYC  = 35,
    parameter int LOC_REARM_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic bus_below_prewake_i,
    input  logic bus_dominant_i,
    input  logic bus_above_prewake_i,
    input  logic wake_sw_n_i,
    output logic rx_enable_o,
    output logic remote_wake_o,
    output logic local_wake_o
);

    localparam int NFLAG = 4;
    // flag order: {switch, above, dominant, below}; idle levels high for switch and above
    localparam logic [NFLAG-1:0] IDLE_LVL = 4'b1100;

    logic [NFLAG-1:0] raw_flags, syn_flags;

    assign raw_flags = {wake_sw_n_i, bus_above_prewake_i, bus_dominant_i, bus_below_prewake_i};

    swd_sync #(
        .WIDTH  (NFLAG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_LVL)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_flags),
        .q    (syn_flags)
    );

    swd_remote #(
        .FILT_CYC (BUS_FILT_CYC),
        .MON_CYC  (MON_CYC),
        .REARM_CYC(BUS_REARM_CYC)
    ) u_remote (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep_i(sleep_i),
        .lo_i   (syn_flags[0]),
        .dom_i  (syn_flags[1]),
        .hi_i   (syn_flags[2]),
        .rx_en_o(rx_enable_o),
        .wake_o (remote_wake_o)
    );

    swd_local #(
        .FILT_CYC (LOC_FILT_CYC),
        .REARM_CYC(LOC_REARM_CYC)
    ) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep_i(sleep_i),
        .sw_n_i (syn_flags[3]),
        .wake_o (local_wake_o)
    );

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int MON_CYC = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic bus_below_prewake_i,
    input logic bus_dominant_i,
    input logic wake_sw_n_i,
    input logic rx_enable_o,
    input logic remote_wake_o,
    input logic local_wake_o
);

    logic [31:0] rx_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rx_run <= '0;
        else if (rx_enable_o) rx_run <= rx_run + 32'd1;
        else                  rx_run <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> (!rx_enable_o && !remote_wake_o && !local_wake_o));

    assert_wake_in_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_wake_o || local_wake_o) |-> $past(sleep_i));

    assert_rx_from_prewake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enable_o) |-> $past(bus_below_prewake_i, 3));

    assert_remote_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake_o |-> !$past(bus_dominant_i, 3));

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable_o |-> (rx_run < 32'(MON_CYC)));

    assert_fire_rx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake_o |-> !rx_enable_o);

    assert_local_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake_o |-> !$past(wake_sw_n_i, 3));

    assert_remote_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake_o |=> !remote_wake_o);

    assert_local_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake_o |=> !local_wake_o);

endmodule

bind sleep_wake_detect swd_checker #(.MON_CYC(MON_CYC)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .sleep_i            (sleep_i),
    .bus_below_prewake_i(bus_below_prewake_i),
    .bus_dominant_i     (bus_dominant_i),
    .wake_sw_n_i        (wake_sw_n_i),
    .rx_enable_o        (rx_enable_o),
    .remote_wake_o      (remote_wake_o),
    .local_wake_o       (local_wake_o)
);

// File: tb/sim_sleep_wake_detect.sv
`timescale 1ns/1ps
module sim_sleep_wake_detect;

    localparam int BF = 8;
    localparam int MW = 60;
    localparam int BR = 4;
    localparam int LF = 6;
    localparam int LR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0;
    logic lo = 1'b0, dom = 1'b0, hi = 1'b1;
    logic wsw = 1'b1;
    logic rx_en, rwake, lwake;

    int total = 0;
    int bad = 0;
    int rem_cnt = 0, loc_cnt = 0, both_cnt = 0, dbl = 0;
    logic prev_r = 1'b0, prev_l = 1'b0;

    always #5 clk = ~clk;

    sleep_wake_detect #(
        .SYNC_STAGES  (2),
        .BUS_FILT_CYC (BF),
        .MON_CYC      (MW),
        .BUS_REARM_CYC(BR),
        .LOC_FILT_CYC (LF),
        .LOC_REARM_CYC(LR)
    ) u0 (
        .clk                (clk),
        .rst_n              (rst_n),
        .sleep_i            (sleep_i),
        .bus_below_prewake_i(lo),
        .bus_dominant_i     (dom),
        .bus_above_prewake_i(hi),
        .wake_sw_n_i        (wsw),
        .rx_enable_o        (rx_en),
        .remote_wake_o      (rwake),
        .local_wake_o       (lwake)
    );

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rwake) rem_cnt++;
            if (lwake) loc_cnt++;
            if (rwake && lwake) both_cnt++;
            if ((rwake && prev_r) || (lwake && prev_l)) dbl++;
            prev_r = rwake;
            prev_l = lwake;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_rec();
        lo = 1'b0; dom = 1'b0; hi = 1'b1;
    endtask

    task automatic bus_float();
        lo = 1'b1; dom = 1'b0; hi = 1'b0;
    endtask

    task automatic bus_dom();
        lo = 1'b1; dom = 1'b1; hi = 1'b0;
    endtask

    task automatic t_idle();
        chk(!rx_en && !rwake && !lwake, "R1 reset outputs", int'({rx_en, rwake, lwake}), 0);
        wsw = 1'b0;
        bus_dom();
        tick(30);
        chk(rx_en == 1'b0, "R1 rx off while awake", rx_en, 0);
        chk(rem_cnt + loc_cnt == 0, "R1 no wake while awake", rem_cnt + loc_cnt, 0);
        wsw = 1'b1;
        bus_rec();
        tick(5);
        sleep_i = 1'b1;
        tick(20);
    endtask

    task automatic t_local_filter();
        wsw = 1'b0; tick(LF);
        wsw = 1'b1; tick(10);
        chk(loc_cnt == 0, "R8 low of filter length ignored", loc_cnt, 0);
        wsw = 1'b0;
        tick(LF + 2);
        chk(lwake == 1'b0, "R8 pulse not early", lwake, 0);
        tick(1);
        chk(lwake == 1'b1, "R8 pulse at filter+3", lwake, 1);
        tick(1);
        chk(lwake == 1'b0, "R10 local pulse one cycle", lwake, 0);
        chk(loc_cnt == 1, "R8 one local wake", loc_cnt, 1);
    endtask

    task automatic t_local_lock();
        tick(30);
        chk(loc_cnt == 1, "R9 held low no repeat", loc_cnt, 1);
        wsw = 1'b1; tick(LR);
        wsw = 1'b0; tick(30);
        chk(loc_cnt == 1, "R9 short high not rearm", loc_cnt, 1);
        wsw = 1'b1; tick(LR + 1);
        wsw = 1'b0; tick(30);
        chk(loc_cnt == 2, "R9 long high rearms", loc_cnt, 2);
        wsw = 1'b1; tick(10);
    endtask

    task automatic t_sleep_entry();
        sleep_i = 1'b0; tick(1);
        sleep_i = 1'b1; tick(2);
        wsw = 1'b0; tick(20);
        chk(loc_cnt == 2, "R2 locked after sleep entry", loc_cnt, 2);
        wsw = 1'b1; tick(10);
        wsw = 1'b0; tick(20);
        chk(loc_cnt == 3, "R2 armed after high interval", loc_cnt, 3);
        wsw = 1'b1; tick(10);
    endtask

    task automatic t_remote_good();
        bus_float();
        tick(2);
        chk(rx_en == 1'b0, "R3 rx not early", rx_en, 0);
        tick(1);
        chk(rx_en == 1'b1, "R3 rx on after 3", rx_en, 1);
        bus_dom();
        tick(BF + 1);
        bus_rec();
        tick(2);
        chk(rwake == 1'b0, "R4 pulse not early", rwake, 0);
        tick(1);
        chk(rwake == 1'b1, "R4 pulse 3 after release", rwake, 1);
        // lockout right after wake
        bus_dom();
        tick(8);
        chk(rx_en == 1'b0, "R7 rx stays off in lockout", rx_en, 0);
        tick(7);
        bus_rec();
        tick(10);
        chk(rem_cnt == 1, "R7 no wake in lockout", rem_cnt, 1);
    endtask

    task automatic t_remote_short_dom();
        bus_dom(); tick(BF);
        bus_rec(); tick(10);
        chk(rem_cnt == 1, "R4 dominant of filter length ignored", rem_cnt, 1);
        chk(rx_en == 1'b1, "R5 window still open", rx_en, 1);
        tick(MW);
        chk(rx_en == 1'b0, "R5 window closed", rx_en, 0);
        chk(rem_cnt == 1, "R5 no wake after expiry", rem_cnt, 1);
    endtask

    task automatic t_float();
        bus_float();
        tick(MW + 2);
        chk(rx_en == 1'b1, "R5 rx high through window", rx_en, 1);
        tick(1);
        chk(rx_en == 1'b0, "R5 rx off at window end", rx_en, 0);
        tick(10);
        bus_rec(); tick(BR);
        bus_dom(); tick(15);
        chk(rx_en == 1'b0, "R7 short recessive keeps lock", rx_en, 0);
        bus_rec(); tick(10);
        chk(rem_cnt == 1, "R7 no wake before rearm", rem_cnt, 1);
        bus_dom(); tick(15);
        bus_rec(); tick(6);
        chk(rem_cnt == 2, "R7 wake after rearm", rem_cnt, 2);
        tick(10);
    endtask

    task automatic t_short();
        bus_dom();
        tick(MW + 20);
        chk(rx_en == 1'b0, "R6 rx off on short", rx_en, 0);
        chk(rem_cnt == 2, "R6 no wake while shorted", rem_cnt, 2);
        bus_rec();
        tick(2);
        chk(rwake == 1'b0, "R6 pulse not early", rwake, 0);
        tick(1);
        chk(rwake == 1'b1, "R6 pulse on release", rwake, 1);
        chk(rx_en == 1'b0, "R6 rx low during pulse", rx_en, 0);
        tick(10);
    endtask

    task automatic t_sleep_exit();
        bus_float();
        tick(5);
        chk(rx_en == 1'b1, "R1 window opened", rx_en, 1);
        sleep_i = 1'b0;
        tick(1);
        chk(rx_en == 1'b0, "R1 rx drops on wake exit", rx_en, 0);
        sleep_i = 1'b1;
        bus_rec();
        tick(10);
        wsw = 1'b0; tick(4);
        sleep_i = 1'b0; tick(1);
        sleep_i = 1'b1; tick(20);
        chk(loc_cnt == 3, "R1 partial local discarded", loc_cnt, 3);
        chk(rem_cnt == 3, "R1 partial remote discarded", rem_cnt, 3);
        wsw = 1'b1; tick(10);
    endtask

    task automatic t_both();
        bus_dom(); tick(10);
        wsw = 1'b0; tick(LF);
        bus_rec(); tick(10);
        chk(both_cnt == 1, "R10 simultaneous pulses", both_cnt, 1);
        chk(rem_cnt == 4 && loc_cnt == 4, "R10 each channel once", rem_cnt * 10 + loc_cnt, 44);
        wsw = 1'b1; tick(10);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_idle();
        t_local_filter();
        t_local_lock();
        t_sleep_entry();
        t_remote_good();
        t_remote_short_dom();
        t_float();
        t_short();
        t_sleep_exit();
        t_both();
        chk(dbl == 0, "R10 no multi-cycle pulse", dbl, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule